// File: doc/BRIEF.md
# MCTP SMBus Packet Receive Validator

This block sits behind an SMBus target engine that already decodes bits, addresses and start/stop conditions. It receives one block-write transaction at a time as a byte stream framed by a start pulse and a stop pulse. When the stop arrives it decides whether to accept or drop the packet. It then follows the assembly of multi-packet messages using the start-of-message flag and a two-bit packet sequence number. For an accepted data packet it streams the payload out one byte per cycle. A control-type message is flagged for a separate command engine rather than streamed. The block also keeps the reply context (source address, source endpoint ID and tag) taken from the first packet of the current message.

The byte stream after the target address is laid out as follows: index 1 is the command code 0x0F, index 2 is the byte count, index 3 is the source slave address, index 4 is the header version, index 5 is the destination endpoint ID, index 6 is the source endpoint ID and index 7 is the flags byte. The payload starts at index 8 and the packet error code (PEC) is the last byte. Index 0 is the block's own address byte, inserted by the block itself. In the flags byte, bit 7 marks start-of-message (SOM), bit 6 marks end-of-message (EOM), bits 5:4 hold the sequence number, bit 3 is the tag owner and bits 2:0 hold the tag.

The upstream engine must hold each stop pulse apart from the last byte strobe. It starts the next transaction only after `payloadValid` has fallen.

Top module: `mctp_rx_validator`

## Requirements
- R1: After reset, `pktAccept`, `pktDrop`, `msgAbort`, `ctrlMsg` and `payloadValid` are low. Each start pulse restarts the packet with `{ownAddr,1'b0}` as byte 0 and a length of 1. A packet whose PEC was computed for a different own address is therefore dropped.
- R2: A packet is dropped unless its byte count (index 2) plus 3 equals the received length minus 1. The received length counts byte 0.
- R3: A packet is dropped unless the CRC-8 with polynomial x^8+x^2+x+1 (0x07), starting from 0, computed over every byte but the last (byte 0 included), equals the last byte.
- R4: A packet is dropped when its destination endpoint ID (index 5) differs from `ownEid`.
- R5: A packet is dropped when its received length is below 10, meaning it carries no payload byte. It is also dropped when it exceeds 73 bytes (8 header and transport bytes, 64 payload bytes and the PEC).
- R6: An accepted SOM packet updates `replyAddr` from index 3, `replyEid` from index 6 and `replyTag` from flags bits 2:0. These values then hold until the next accepted SOM packet.
- R7: An accepted SOM packet that arrives while a message is in progress raises `msgAbort` together with `pktAccept`.
- R8: When the first payload byte of an accepted SOM packet, masked with 0x7F, is 0, `ctrlMsg` pulses with `pktAccept` and no payload is streamed.
- R9: A packet without SOM is dropped when no message is in progress.
- R10: A continuation packet is accepted only if its sequence number equals the stored sequence plus 1 modulo 4, and the stored value then advances. On a mismatch the packet is dropped and the stored value is kept.
- R11: All result pulses last one cycle and appear in the cycle after the clock edge that samples `stopIn`. An accepted non-control packet streams its payload bytes (index 8 up to, but not including, the PEC) starting in that same cycle, one byte per cycle, in order, with `payloadLast` on the final byte.
- R12: An accepted packet that carries EOM ends the message, so a following continuation packet is dropped. Two continuation packets may be accepted in a row when neither carries EOM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ownAddr | input | 7 | Own 7-bit slave address |
| ownEid | input | 8 | Own endpoint ID |
| startIn | input | 1 | Write-transaction start pulse |
| byteValid | input | 1 | Received byte strobe |
| byteIn | input | 8 | Received byte |
| stopIn | input | 1 | Transaction stop pulse |
| pktAccept | output | 1 | Packet accepted pulse |
| pktDrop | output | 1 | Packet dropped pulse |
| msgAbort | output | 1 | In-progress message abandoned pulse |
| ctrlMsg | output | 1 | Accepted packet is a control message |
| replyAddr | output | 8 | Captured source address byte |
| replyEid | output | 8 | Captured source endpoint ID |
| replyTag | output | 3 | Captured message tag |
| payloadValid | output | 1 | Payload byte valid |
| payloadData | output | 8 | Payload byte |
| payloadLast | output | 1 | Final payload byte |

## Verification
Single-packet data messages with payloads of 1, 5 and 64 bytes show that streaming and framing are correct. Packets that differ from a good one in exactly one field (byte count, PEC, destination ID, own address, length 9 or 74) show that each drop check acts on its own. A three-packet message containing one out-of-order packet, a wrap from sequence 3 to 0, and a stray continuation after EOM separate the sequence-tracking rules from the framing rules. A control packet whose type byte has bit 7 set, and a SOM packet sent in the middle of a message, separate the control path from the abort path.

// File: rtl/mctp_rx_pkg.sv
package mctp_rx_pkg;

  localparam int unsigned HDR_BYTES = 8;

  typedef struct packed {
    logic [7:0] rxLen;
    logic       overflow;
    logic [7:0] byteCount;
    logic [7:0] srcAddr;
    logic [7:0] destEid;
    logic [7:0] srcEid;
    logic       som;
    logic       eom;
    logic [1:0] seq;
    logic [2:0] tag;
    logic [6:0] msgType;
    logic       pecOk;
  } rxSummary_t;

  typedef struct packed {
    logic       drainStart;
    logic [7:0] drainLen;
  } dpStrobe_t;

  function automatic logic [7:0] crc8Step(input logic [7:0] crcIn, input logic [7:0] data);
    logic [7:0] c;
    c = crcIn ^ data;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/mctp_rx_datapath.sv
module mctp_rx_datapath
  import mctp_rx_pkg::*;
#(
  parameter int unsigned PAYLOAD_MAX = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [6:0] ownAddr,
  input  logic       startIn,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  input  dpStrobe_t  strobe,
  output rxSummary_t summary,
  output logic       payloadValid,
  output logic [7:0] payloadData,
  output logic       payloadLast
);
  localparam int unsigned CAP  = HDR_BYTES + PAYLOAD_MAX + 1;
  localparam int unsigned PBUF = PAYLOAD_MAX + 1;
  localparam int unsigned IDXW = $clog2(PBUF);

  logic [7:0] rxLen, crcCur, crcPrev, lastByte;
  logic       overflow;
  logic [7:0] pbuf [PBUF];
  logic       draining;
  logic [7:0] drainCnt, drainLen;

  // Header capture and running CRC; crcPrev trails by one byte so it covers all but the last
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxLen    <= '0;
      overflow <= 1'b0;
      crcCur   <= '0;
      crcPrev  <= '0;
      lastByte <= '0;
      summary.byteCount <= '0;
      summary.srcAddr   <= '0;
      summary.destEid   <= '0;
      summary.srcEid    <= '0;
      summary.som       <= 1'b0;
      summary.eom       <= 1'b0;
      summary.seq       <= '0;
      summary.tag       <= '0;
      summary.msgType   <= '0;
    end else if (startIn) begin
      rxLen    <= 8'd1;
      overflow <= 1'b0;
      crcCur   <= crc8Step(8'h00, {ownAddr, 1'b0});
      crcPrev  <= 8'h00;
      lastByte <= {ownAddr, 1'b0};
    end else if (byteValid) begin
      crcPrev  <= crcCur;
      crcCur   <= crc8Step(crcCur, byteIn);
      lastByte <= byteIn;
      if (rxLen >= 8'(CAP)) overflow <= 1'b1;
      else                  rxLen    <= rxLen + 8'd1;
      case (rxLen)
        8'd2: summary.byteCount <= byteIn;
        8'd3: summary.srcAddr   <= byteIn;
        8'd5: summary.destEid   <= byteIn;
        8'd6: summary.srcEid    <= byteIn;
        8'd7: begin
          summary.som <= byteIn[7];
          summary.eom <= byteIn[6];
          summary.seq <= byteIn[5:4];
          summary.tag <= byteIn[2:0];
        end
        8'd8: summary.msgType <= byteIn[6:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (byteValid && !startIn && rxLen >= 8'(HDR_BYTES) && rxLen < 8'(CAP))
      pbuf[IDXW'(rxLen - 8'(HDR_BYTES))] <= byteIn;
  end

  assign summary.rxLen    = rxLen;
  assign summary.overflow = overflow;
  assign summary.pecOk    = (crcPrev == lastByte);

  // Payload drain, launched by the control strobe at the stop edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      draining <= 1'b0;
      drainCnt <= '0;
      drainLen <= '0;
    end else if (strobe.drainStart) begin
      draining <= 1'b1;
      drainCnt <= '0;
      drainLen <= strobe.drainLen;
    end else if (draining) begin
      if (drainCnt + 8'd1 == drainLen) draining <= 1'b0;
      drainCnt <= drainCnt + 8'd1;
    end
  end

  assign payloadValid = draining;
  assign payloadData  = pbuf[IDXW'(drainCnt)];
  assign payloadLast  = draining && (drainCnt + 8'd1 == drainLen);

  // R11
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    payloadLast |-> payloadValid);
  // R11
  drain_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(payloadValid) |-> $past(strobe.drainStart));
  // R5
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(byteValid) && $past(rxLen) == 8'(CAP));
endmodule

// File: rtl/mctp_rx_ctrl.sv
module mctp_rx_ctrl
  import mctp_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] ownEid,
  input  logic       stopIn,
  input  rxSummary_t summary,
  output dpStrobe_t  strobe,
  output logic       pktAccept,
  output logic       pktDrop,
  output logic       msgAbort,
  output logic       ctrlMsg,
  output logic [7:0] replyAddr,
  output logic [7:0] replyEid,
  output logic [2:0] replyTag
);
  typedef enum logic [1:0] {DEC_DROP, DEC_SOM, DEC_CONT} decision_e;

  logic      inMsg;
  logic [1:0] seqReg;
  logic      frameOk, isCtrl;
  decision_e decision;

  always_comb begin
    frameOk = !summary.overflow
           && summary.rxLen >= 8'd10
           && ({1'b0, summary.byteCount} + 9'd3 == {1'b0, summary.rxLen} - 9'd1)
           && summary.pecOk
           && summary.destEid == ownEid;
    isCtrl = (summary.msgType == 7'd0);
    if (!frameOk)                          decision = DEC_DROP;
    else if (summary.som)                  decision = DEC_SOM;
    else if (!inMsg)                       decision = DEC_DROP;
    else if (summary.seq != seqReg + 2'd1) decision = DEC_DROP;
    else                                   decision = DEC_CONT;
  end

  always_comb begin
    strobe.drainStart = stopIn && ((decision == DEC_CONT) || (decision == DEC_SOM && !isCtrl));
    strobe.drainLen   = summary.rxLen - 8'd9;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inMsg     <= 1'b0;
      seqReg    <= '0;
      pktAccept <= 1'b0;
      pktDrop   <= 1'b0;
      msgAbort  <= 1'b0;
      ctrlMsg   <= 1'b0;
      replyAddr <= '0;
      replyEid  <= '0;
      replyTag  <= '0;
    end else begin
      pktAccept <= 1'b0;
      pktDrop   <= 1'b0;
      msgAbort  <= 1'b0;
      ctrlMsg   <= 1'b0;
      if (stopIn) begin
        case (decision)
          DEC_SOM: begin
            pktAccept <= 1'b1;
            msgAbort  <= inMsg;
            ctrlMsg   <= isCtrl;
            inMsg     <= !summary.eom;
            seqReg    <= summary.seq;
            replyAddr <= summary.srcAddr;
            replyEid  <= summary.srcEid;
            replyTag  <= summary.tag;
          end
          DEC_CONT: begin
            pktAccept <= 1'b1;
            inMsg     <= !summary.eom;
            seqReg    <= summary.seq;
          end
          default: pktDrop <= 1'b1;
        endcase
      end
    end
  end

  // R11
  accept_drop_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pktAccept && pktDrop));
  // R11
  result_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktAccept || pktDrop) |-> $past(stopIn));
  // R7
  abort_with_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgAbort |-> pktAccept);
  // R8
  ctrl_with_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlMsg |-> pktAccept);
  // R10
  seq_hold_on_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktDrop |-> $stable(seqReg));
endmodule

// File: rtl/mctp_rx_validator.sv
module mctp_rx_validator
  import mctp_rx_pkg::*;
#(
  parameter int unsigned PAYLOAD_MAX = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [6:0] ownAddr,
  input  logic [7:0] ownEid,
  input  logic       startIn,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  input  logic       stopIn,
  output logic       pktAccept,
  output logic       pktDrop,
  output logic       msgAbort,
  output logic       ctrlMsg,
  output logic [7:0] replyAddr,
  output logic [7:0] replyEid,
  output logic [2:0] replyTag,
  output logic       payloadValid,
  output logic [7:0] payloadData,
  output logic       payloadLast
);
  rxSummary_t summary;
  dpStrobe_t  strobe;

  mctp_rx_datapath #(.PAYLOAD_MAX(PAYLOAD_MAX)) dp_i (
    .clk(clk), .rstN(rstN), .ownAddr(ownAddr), .startIn(startIn),
    .byteValid(byteValid), .byteIn(byteIn), .strobe(strobe), .summary(summary),
    .payloadValid(payloadValid), .payloadData(payloadData), .payloadLast(payloadLast)
  );

  mctp_rx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ownEid(ownEid), .stopIn(stopIn), .summary(summary),
    .strobe(strobe), .pktAccept(pktAccept), .pktDrop(pktDrop), .msgAbort(msgAbort),
    .ctrlMsg(ctrlMsg), .replyAddr(replyAddr), .replyEid(replyEid), .replyTag(replyTag)
  );
endmodule

// File: tb/mctp_rx_validator_tb_top.sv
module mctp_rx_validator_tb_top;
  typedef byte unsigned bq_t[$];

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0] ownAddr = 7'h1D;
  logic [7:0] ownEid = 8'h09;
  logic startIn = 1'b0, byteValid = 1'b0, stopIn = 1'b0;
  logic [7:0] byteIn = '0;
  logic pktAccept, pktDrop, msgAbort, ctrlMsg, payloadValid, payloadLast;
  logic [7:0] replyAddr, replyEid, payloadData;
  logic [2:0] replyTag;

  int vectors = 0;
  int miscompares = 0;

  // behavioural model state
  bit mInMsg = 0;
  int mSeq = 0;
  int mReplyAddr = 0, mReplyEid = 0, mReplyTag = 0;

  always #4 clk = ~clk;

  mctp_rx_validator dut_i (
    .clk(clk), .rstN(rstN), .ownAddr(ownAddr), .ownEid(ownEid), .startIn(startIn),
    .byteValid(byteValid), .byteIn(byteIn), .stopIn(stopIn), .pktAccept(pktAccept),
    .pktDrop(pktDrop), .msgAbort(msgAbort), .ctrlMsg(ctrlMsg), .replyAddr(replyAddr),
    .replyEid(replyEid), .replyTag(replyTag), .payloadValid(payloadValid),
    .payloadData(payloadData), .payloadLast(payloadLast)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic int crcOf(bq_t q, int n);
    int c = 0;
    for (int i = 0; i < n; i++) begin
      c = c ^ q[i];
      for (int b = 0; b < 8; b++) c = (c & 8'h80) ? (((c << 1) ^ 8'h07) & 8'hFF) : ((c << 1) & 8'hFF);
    end
    return c;
  endfunction

  // bytes after the address byte; pecAddr is the address the PEC is computed for
  function automatic bq_t mk(input int nPay, input int flags, input int dEid, input int bcAdj,
                             input bit pecBad, input int firstPay, input int pecAddr);
    bq_t q;
    bq_t full;
    q.push_back(8'h0F);
    q.push_back(8'(5 + nPay + bcAdj));
    q.push_back(8'h21);
    q.push_back(8'h01);
    q.push_back(8'(dEid));
    q.push_back(8'h08);
    q.push_back(8'(flags));
    for (int i = 0; i < nPay; i++) q.push_back(8'(i == 0 ? firstPay : (i * 7 + 3)));
    full = q;
    full.push_front(8'(pecAddr << 1));
    q.push_back(8'(crcOf(full, full.size()) ^ (pecBad ? 8'hFF : 8'h00)));
    return q;
  endfunction

  function automatic int fl(input bit som, input bit eom, input int seq, input int tag);
    return (som << 7) | (eom << 6) | ((seq & 3) << 4) | 8'h08 | (tag & 7);
  endfunction

  task automatic runPkt(input bq_t pkt, input string req);
    bq_t full;
    int len, expAcc, expDrop, expAbort, expCtrl, seq;
    bit drop, som, eom;
    full = pkt;
    full.push_front(8'({ownAddr, 1'b0}));
    len = full.size();
    drop = (len < 10) || (len > 73) || (full[2] + 3 != len - 1)
        || (crcOf(full, len - 1) != full[len-1]) || (full[5] != ownEid);
    som = (len > 7) ? full[7][7] : 0;
    eom = (len > 7) ? full[7][6] : 0;
    seq = (len > 7) ? ((full[7] >> 4) & 3) : 0;
    expAcc = 0; expDrop = 0; expAbort = 0; expCtrl = 0;
    if (!drop && som) begin
      expAcc = 1; expAbort = mInMsg; expCtrl = ((full[8] & 8'h7F) == 0);
      mInMsg = !eom; mSeq = seq;
      mReplyAddr = full[3]; mReplyEid = full[6]; mReplyTag = full[7] & 7;
    end else if (!drop && mInMsg && seq == ((mSeq + 1) % 4)) begin
      expAcc = 1; mInMsg = !eom; mSeq = seq;
    end else begin
      expDrop = 1;
    end
    startIn = 1'b1; tick(); startIn = 1'b0;
    foreach (pkt[i]) begin
      byteIn = pkt[i]; byteValid = 1'b1; tick();
      chk(!(pktAccept | pktDrop | msgAbort | ctrlMsg | payloadValid), {req, " idle during bytes R11"},
          {pktAccept, pktDrop, msgAbort, ctrlMsg, payloadValid}, 0);
    end
    byteValid = 1'b0; stopIn = 1'b1; tick(); stopIn = 1'b0;
    chk(pktAccept == expAcc, {req, " accept"}, pktAccept, expAcc);
    chk(pktDrop == expDrop, {req, " drop"}, pktDrop, expDrop);
    chk(msgAbort == expAbort, {req, " abort R7"}, msgAbort, expAbort);
    chk(ctrlMsg == expCtrl, {req, " ctrl R8"}, ctrlMsg, expCtrl);
    chk(replyAddr == mReplyAddr, {req, " replyAddr R6"}, replyAddr, mReplyAddr);
    chk(replyEid == mReplyEid, {req, " replyEid R6"}, replyEid, mReplyEid);
    chk(replyTag == mReplyTag, {req, " replyTag R6"}, replyTag, mReplyTag);
    if (expAcc && !expCtrl) begin
      for (int i = 8; i < len - 1; i++) begin
        chk(payloadValid === 1'b1, {req, " payload valid R11"}, payloadValid, 1);
        chk(payloadData == full[i], {req, " payload data R11"}, payloadData, full[i]);
        chk(payloadLast == (i == len - 2), {req, " payload last R11"}, payloadLast, i == len - 2);
        tick();
      end
    end else begin
      tick();
    end
    chk(payloadValid == 1'b0, {req, " stream ended R11"}, payloadValid, 0);
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk(!(pktAccept | pktDrop | msgAbort | ctrlMsg | payloadValid), "R1 reset state",
        {pktAccept, pktDrop, msgAbort, ctrlMsg, payloadValid}, 0);
    rstN = 1'b1;
    tick();
    // R11 single-packet data message, 5 bytes
    runPkt(mk(5, fl(1, 1, 2, 5), 9, 0, 0, 8'h7E, 7'h1D), "R11 single");
    // R8 control type with bit 7 set
    runPkt(mk(3, fl(1, 1, 0, 1), 9, 0, 0, 8'h80, 7'h1D), "R8 control");
    // R3 bad PEC
    runPkt(mk(4, fl(1, 1, 0, 2), 9, 0, 1, 8'h7E, 7'h1D), "R3 pec");
    // R2 bad byte count
    runPkt(mk(4, fl(1, 1, 0, 2), 9, 1, 0, 8'h7E, 7'h1D), "R2 count");
    // R4 wrong destination EID
    runPkt(mk(4, fl(1, 1, 0, 2), 8'h0A, 0, 0, 8'h7E, 7'h1D), "R4 eid");
    // R1 PEC covers a different own address
    runPkt(mk(4, fl(1, 1, 0, 2), 9, 0, 0, 8'h7E, 7'h1E), "R1 seed");
    // R5 no payload, and too long
    runPkt(mk(0, fl(1, 1, 0, 2), 9, 0, 0, 8'h7E, 7'h1D), "R5 short");
    runPkt(mk(65, fl(1, 1, 0, 2), 9, 0, 0, 8'h7E, 7'h1D), "R5 overflow");
    runPkt(mk(64, fl(1, 1, 0, 4), 9, 0, 0, 8'h7E, 7'h1D), "R5 full size");
    runPkt(mk(1, fl(1, 1, 0, 4), 9, 0, 0, 8'h7E, 7'h1D), "R11 one byte");
    // R9 continuation with no message
    runPkt(mk(3, fl(0, 0, 1, 0), 9, 0, 0, 8'h11, 7'h1D), "R9 orphan");
    // R10 sequence tracking and R12 end of message
    runPkt(mk(3, fl(1, 0, 1, 6), 9, 0, 0, 8'h7E, 7'h1D), "R10 som seq1");
    runPkt(mk(3, fl(0, 0, 2, 6), 9, 0, 0, 8'h33, 7'h1D), "R10 seq2");
    runPkt(mk(3, fl(0, 0, 0, 6), 9, 0, 0, 8'h44, 7'h1D), "R10 bad seq");
    runPkt(mk(3, fl(0, 0, 3, 6), 9, 0, 0, 8'h55, 7'h1D), "R12 seq3 no eom");
    runPkt(mk(2, fl(0, 1, 0, 6), 9, 0, 0, 8'h66, 7'h1D), "R10 wrap eom");
    runPkt(mk(3, fl(0, 0, 1, 6), 9, 0, 0, 8'h77, 7'h1D), "R12 after eom");
    // R7 SOM during a message aborts it
    runPkt(mk(3, fl(1, 0, 3, 3), 9, 0, 0, 8'h7E, 7'h1D), "R7 first");
    runPkt(mk(2, fl(1, 1, 1, 7), 9, 0, 0, 8'h05, 7'h1D), "R7 restart");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule